// File: doc/BRIEF.md
# Word Stack Engine over a Byte Memory

This block moves 16-bit words onto and off a stack that lives in a byte-wide memory. It keeps a 16-bit stack offset and a 16-bit segment value. From these it forms 20-bit byte addresses and turns each word command into two ordered single-byte accesses.

A push stores the upper byte one below the current offset and the lower byte two below. The offset then drops by two. A pop fetches the lower byte at the current offset and the upper byte one above it. The offset then rises by two, and the assembled word is presented together with a one-cycle completion pulse.

The engine takes a new command only while it is idle. It does take one in the very cycle that reports completion of the previous command, so commands can run back to back. The memory port carries one access per cycle. Read data returns one cycle after the read is issued.

Top module: `wstack_engine`

## Requirements
- R1: While reset is asserted the engine reports busy and no done. After release it loads the offset from `init_sp` and the segment from `init_seg`, then drops busy. Immediately after that load, `sp_out` equals `init_sp` and `pop_data` is zero.
- R2: A push performs two write cycles in consecutive cycles. The cycle after acceptance writes bits 15:8 of the word to offset SP-1. The next cycle writes bits 7:0 to offset SP-2.
- R3: After a push, `done` is high for exactly one cycle, in the cycle after the second write. In that cycle busy is low and `sp_out` equals the old offset minus 2.
- R4: A pop issues reads in consecutive cycles, first at offset SP and then at offset SP+1. Read data arrives one cycle after each read. `pop_data` equals {byte read at SP+1, byte read at SP}, and `done` pulses for one cycle two cycles after the second read.
- R5: After a pop, `sp_out` equals the old offset plus 2, valid in the `done` cycle.
- R6: Every memory address equals (segment × 16) + offset, truncated to 20 bits. Offsets SP-1, SP-2 and SP+1 wrap modulo 2^16.
- R7: Words are returned last-in first-out: pops following pushes of A, B, C return C, B, A.
- R8: Commands presented while busy are ignored. They change neither the offset, nor the accesses of the running command, nor the state after it.
- R9: If push and pop are both requested in an idle cycle, the push is performed and the pop is dropped.
- R10: A command presented in the cycle where `done` is high is accepted, and its first access occurs in the following cycle.
- R11: Write and read strobes are never high together, and neither is high while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_sp | input | 16 | Offset value loaded after reset |
| init_seg | input | 16 | Segment value loaded after reset |
| cmd_push | input | 1 | Request to push `push_data` |
| cmd_pop | input | 1 | Request to pop one word |
| push_data | input | 16 | Word to push, sampled on acceptance |
| busy | output | 1 | Engine is executing or loading |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 16 | Last popped word |
| sp_out | output | 16 | Current stack offset |
| mem_addr | output | 20 | Byte address |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_wdata | output | 8 | Byte write data |
| mem_rdata | input | 8 | Byte read data, one cycle after `mem_re` |

## Verification
Two events can occur in the same cycle: the completion pulse of one command and the acceptance of the next. The bench chains its push and pop tasks so that every new request is raised exactly in the `done` cycle of the previous one. It then judges the following cycle's strobe and address against the offset that the finished command should have left behind. A second overlap comes from raising both requests together, and from raising stray requests during the middle cycle of a command. Each of these is checked by the accesses and offset that follow, and by a quiet idle cycle afterwards.

// File: rtl/wstack_pkg.sv
package wstack_pkg;
  typedef enum logic [2:0] {
    ST_LOAD,
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_LO,
    ST_POP_HI,
    ST_POP_FIN
  } wstk_state_e;
endpackage

// File: rtl/wstack_rst_sync.sv
module wstack_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/wstack_addr_gen.sv
module wstack_addr_gen #(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PHYS_W    = 20
) (
  input  logic [OFF_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [PHYS_W-1:0] phys_o
);
  localparam int BASE_W = OFF_W + SEG_SHIFT;
  logic [BASE_W-1:0] base;

  assign base   = {seg_i, {SEG_SHIFT{1'b0}}};
  assign phys_o = PHYS_W'(base) + PHYS_W'(off_i);
endmodule

// File: rtl/wstack_ctrl.sv
module wstack_ctrl
  import wstack_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [OFF_W-1:0]  init_sp,
  input  logic [OFF_W-1:0]  init_seg,
  input  logic              cmd_push,
  input  logic              cmd_pop,
  input  logic [2*BYTE_W-1:0] push_data,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [2*BYTE_W-1:0] pop_data,
  output logic [OFF_W-1:0]  sp_out,
  output logic [OFF_W-1:0]  seg_out,
  output logic [OFF_W-1:0]  acc_off,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata
);
  localparam int DATA_W = 2 * BYTE_W;

  wstk_state_e       state_q, state_d;
  logic [OFF_W-1:0]  sp_q, sp_d, seg_q, seg_d;
  logic [DATA_W-1:0] wdata_q, wdata_d, pop_q, pop_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              done_q, done_d;

  // next-state and datapath steering
  always_comb begin
    state_d   = state_q;
    sp_d      = sp_q;
    seg_d     = seg_q;
    wdata_d   = wdata_q;
    pop_d     = pop_q;
    lo_d      = lo_q;
    done_d    = 1'b0;
    acc_off   = sp_q;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    unique case (state_q)
      ST_LOAD: begin
        sp_d    = init_sp;
        seg_d   = init_seg;
        state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (cmd_push) begin
          wdata_d = push_data;
          state_d = ST_PUSH_HI;
        end else if (cmd_pop) begin
          state_d = ST_POP_LO;
        end
      end
      ST_PUSH_HI: begin
        mem_we    = 1'b1;
        acc_off   = sp_q - OFF_W'(1);
        mem_wdata = wdata_q[DATA_W-1 -: BYTE_W];
        state_d   = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        mem_we    = 1'b1;
        acc_off   = sp_q - OFF_W'(2);
        mem_wdata = wdata_q[BYTE_W-1:0];
        sp_d      = sp_q - OFF_W'(2);
        done_d    = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_POP_LO: begin
        mem_re  = 1'b1;
        state_d = ST_POP_HI;
      end
      ST_POP_HI: begin
        mem_re  = 1'b1;
        acc_off = sp_q + OFF_W'(1);
        lo_d    = mem_rdata;
        state_d = ST_POP_FIN;
      end
      ST_POP_FIN: begin
        pop_d   = {mem_rdata, lo_q};
        sp_d    = sp_q + OFF_W'(2);
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      sp_q    <= '0;
      seg_q   <= '0;
      wdata_q <= '0;
      pop_q   <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sp_q    <= sp_d;
      seg_q   <= seg_d;
      wdata_q <= wdata_d;
      pop_q   <= pop_d;
      lo_q    <= lo_d;
      done_q  <= done_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign pop_data = pop_q;
  assign sp_out   = sp_q;
  assign seg_out  = seg_q;

  // R11
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(mem_we && mem_re) && !(state_q == ST_IDLE && (mem_we || mem_re)));

  // R3
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_PUSH_LO) |=> (sp_q == $past(sp_q) - OFF_W'(2)) && done_q);

  // R5
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_POP_FIN) |=> (sp_q == $past(sp_q) + OFF_W'(2)) && done_q);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R8
  hold_sp_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_PUSH_HI || state_q == ST_POP_LO || state_q == ST_POP_HI)
      |=> $stable(sp_q) && $stable(seg_q));
endmodule

// File: rtl/wstack_engine.sv
module wstack_engine #(
  parameter int BYTE_W    = 8,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PHYS_W    = OFF_W + SEG_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OFF_W-1:0]    init_sp,
  input  logic [OFF_W-1:0]    init_seg,
  input  logic                cmd_push,
  input  logic                cmd_pop,
  input  logic [2*BYTE_W-1:0] push_data,
  output logic                busy,
  output logic                done,
  output logic [2*BYTE_W-1:0] pop_data,
  output logic [OFF_W-1:0]    sp_out,
  output logic [PHYS_W-1:0]   mem_addr,
  output logic                mem_we,
  output logic                mem_re,
  output logic [BYTE_W-1:0]   mem_wdata,
  input  logic [BYTE_W-1:0]   mem_rdata
);
  logic             rst_ni;
  logic [OFF_W-1:0] seg_w, off_w;

  wstack_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  wstack_ctrl #(.BYTE_W(BYTE_W), .OFF_W(OFF_W)) u_ctrl (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .init_sp   (init_sp),
    .init_seg  (init_seg),
    .cmd_push  (cmd_push),
    .cmd_pop   (cmd_pop),
    .push_data (push_data),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .done      (done),
    .pop_data  (pop_data),
    .sp_out    (sp_out),
    .seg_out   (seg_w),
    .acc_off   (off_w),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata)
  );

  wstack_addr_gen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .PHYS_W(PHYS_W)) u_addr (
    .seg_i  (seg_w),
    .off_i  (off_w),
    .phys_o (mem_addr)
  );
endmodule

// File: tb/wstack_engine_tb.sv
module wstack_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] init_sp, init_seg, push_data;
  logic        cmd_push, cmd_pop;
  logic        busy, done, mem_we, mem_re;
  logic [15:0] pop_data, sp_out;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int checks = 0;
  int fails  = 0;
  logic [15:0] sp_m, seg_m;
  int depth = 0;
  logic [7:0] bmem [int];
  logic [7:0] rmem [int];

  always #2.5 clk = ~clk;

  wstack_engine dut_i (
    .clk(clk), .rst_n(rst_n), .init_sp(init_sp), .init_seg(init_seg),
    .cmd_push(cmd_push), .cmd_pop(cmd_pop), .push_data(push_data),
    .busy(busy), .done(done), .pop_data(pop_data), .sp_out(sp_out),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // byte memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'h00;
  end

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return ({4'b0, s} << 4) + {4'b0, o};
  endfunction

  function automatic logic [7:0] ref_rd(input logic [19:0] a);
    return rmem.exists(int'(a)) ? rmem[int'(a)] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // starts and ends at a negedge; the final cycle is the done cycle
  task automatic do_push(input logic [15:0] d, input bit junk, input bit both);
    logic [19:0] a;
    cmd_push = 1'b1; cmd_pop = both; push_data = d;
    @(negedge clk);
    cmd_push = 1'b0; cmd_pop = 1'b0;
    if (junk) begin cmd_push = 1'b1; cmd_pop = 1'b1; push_data = ~d; end
    a = phys(seg_m, sp_m - 16'd1);
    chk("R2 hi we", {31'b0, mem_we}, 32'd1);
    chk("R11 no re", {31'b0, mem_re}, 32'd0);
    chk("R6 hi addr", {12'b0, mem_addr}, {12'b0, a});
    chk("R2 hi byte", {24'b0, mem_wdata}, {24'b0, d[15:8]});
    rmem[int'(a)] = d[15:8];
    @(negedge clk);
    cmd_push = 1'b0; cmd_pop = 1'b0;
    a = phys(seg_m, sp_m - 16'd2);
    chk("R2 lo we", {31'b0, mem_we}, 32'd1);
    chk("R6 lo addr", {12'b0, mem_addr}, {12'b0, a});
    chk("R2 lo byte", {24'b0, mem_wdata}, {24'b0, d[7:0]});
    rmem[int'(a)] = d[7:0];
    @(negedge clk);
    sp_m = sp_m - 16'd2;
    depth++;
    chk("R3 done", {31'b0, done}, 32'd1);
    chk("R3 busy low", {31'b0, busy}, 32'd0);
    chk("R3 R8 sp", {16'b0, sp_out}, {16'b0, sp_m});
  endtask

  task automatic do_pop(input bit junk, output logic [15:0] got);
    logic [15:0] exp;
    exp = {ref_rd(phys(seg_m, sp_m + 16'd1)), ref_rd(phys(seg_m, sp_m))};
    cmd_pop = 1'b1; cmd_push = 1'b0;
    @(negedge clk);
    cmd_pop = 1'b0;
    if (junk) begin cmd_push = 1'b1; cmd_pop = 1'b1; end
    chk("R4 re lo", {31'b0, mem_re}, 32'd1);
    chk("R6 R4 lo addr", {12'b0, mem_addr}, {12'b0, phys(seg_m, sp_m)});
    @(negedge clk);
    cmd_push = 1'b0; cmd_pop = 1'b0;
    chk("R4 re hi", {31'b0, mem_re}, 32'd1);
    chk("R6 R4 hi addr", {12'b0, mem_addr}, {12'b0, phys(seg_m, sp_m + 16'd1)});
    @(negedge clk);
    chk("R11 quiet", {30'b0, mem_we, mem_re}, 32'd0);
    chk("R4 no early done", {31'b0, done}, 32'd0);
    @(negedge clk);
    sp_m = sp_m + 16'd2;
    if (depth > 0) depth--;
    chk("R4 done", {31'b0, done}, 32'd1);
    chk("R4 data", {16'b0, pop_data}, {16'b0, exp});
    chk("R5 sp", {16'b0, sp_out}, {16'b0, sp_m});
    got = pop_data;
  endtask

  task automatic idle_chk(input string req);
    @(negedge clk);
    chk(req, {28'b0, busy, done, mem_we, mem_re}, 32'd0);
    chk(req, {16'b0, sp_out}, {16'b0, sp_m});
  endtask

  task automatic do_reset(input logic [15:0] seg, input logic [15:0] sp);
    rst_n = 1'b0; init_seg = seg; init_sp = sp;
    cmd_push = 1'b0; cmd_pop = 1'b0; push_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'b0, busy}, 32'd1);
    chk("R1 no done", {31'b0, done}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 8 && busy; i++) @(negedge clk);
    chk("R1 idle", {31'b0, busy}, 32'd0);
    chk("R1 sp", {16'b0, sp_out}, {16'b0, sp});
    chk("R1 pop_data", {16'b0, pop_data}, 32'd0);
    seg_m = seg; sp_m = sp; depth = 0;
  endtask

  initial begin
    logic [15:0] w;
    int r;
    r = $urandom(32'h5eed);
    rst_n = 1'b0;
    @(negedge clk);
    // wrap corners: offsets cross 0000/FFFF and the 20-bit sum overflows
    do_reset(16'hFFFF, 16'h0001);
    do_push(16'hA5C3, 1'b0, 1'b0);
    do_pop(1'b0, w);
    chk("R6 wrap word", {16'b0, w}, 32'h0000A5C3);
    idle_chk("R11 idle");

    do_reset(16'h1234, 16'h0100);
    // R7 ordering, chained back to back (R10)
    do_push(16'h1111, 1'b0, 1'b0);
    do_push(16'h2222, 1'b0, 1'b0);
    do_push(16'h3333, 1'b0, 1'b0);
    do_pop(1'b0, w); chk("R7 first", {16'b0, w}, 32'h3333);
    do_pop(1'b0, w); chk("R7 second", {16'b0, w}, 32'h2222);
    do_pop(1'b0, w); chk("R7 third", {16'b0, w}, 32'h1111);
    idle_chk("R10 R11 idle");
    // R9 both requests
    do_push(16'hBEEF, 1'b0, 1'b1);
    idle_chk("R9 pop dropped");
    // R8 stray requests during busy
    do_push(16'h7E81, 1'b1, 1'b0);
    idle_chk("R8 push junk ignored");
    do_pop(1'b1, w);
    chk("R8 pop word", {16'b0, w}, 32'h7E81);
    idle_chk("R8 pop junk ignored");

    for (int n = 0; n < 400; n++) begin
      if (depth > 0 && ($urandom % 2 == 1)) do_pop(($urandom % 8) == 0, w);
      else do_push(16'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0);
      if ($urandom % 5 == 0) idle_chk("R11 gap");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule